// File: doc/BRIEF.md
# Display Controller Interrupt Unit

This block gathers the interrupt events of a raster display controller into four sources: master bus error, vertical compare, next-base-address update and FIFO underflow. Each source has a sticky raw status bit, a mask bit and a write-one-to-clear bit. The block drives one masked output per source and a single combined interrupt line. A global service routine can therefore use the combined line, and separate drivers can each watch one source line.

Event pulses come from the bus master, the base-address transfer logic and the two panel DMA FIFOs. The timing generator supplies four level signals, one for each frame phase. A two-bit field in a control register selects which phase raises the vertical compare source on entry. When a bus error is taken, the block holds the master in an error state until software clears the source. On that clear it sends the master a one-cycle restart pulse that returns it to the start of a frame.

Register access uses a plain write strobe, a two-bit address and a combinational read-data bus. Reset is synchronous and active high.

Top module: `disp_irq_unit`

## Requirements
- R1: Source bit positions are 0 = bus error, 1 = vertical compare, 2 = next-base update and 3 = FIFO underflow. The raw status register at address 1 is read-only and shows every raw bit whatever the mask holds.
- R2: The mask register at address 0 is read/write in bits [3:0]. `irq_src[i]` is high exactly when raw bit i and mask bit i are both 1, and `irq_any` is the OR of `irq_src`.
- R3: A write to the clear register at address 2 clears each raw bit whose data bit is 1, from the next cycle. Data bits at 0 leave their raw bits unchanged, and the register reads as 0.
- R4: A `mst_err_resp` pulse sets raw bit 0 and raises `mst_err_hold` from the next cycle. `mst_err_hold` stays high until bit 0 is cleared.
- R5: Clearing bit 0 while held drops `mst_err_hold` and pulses `mst_restart` high for exactly one cycle, in the same cycle.
- R6: Bits [1:0] of the control register at address 3 select the phase: 00 = vertical sync, 01 = back porch, 10 = active video, 11 = front porch. A rising edge of the selected phase input sets raw bit 1. A phase held high, or an edge on a phase that is not selected, does not set it.
- R7: A pulse on either `base_ld_upper` or `base_ld_lower` sets raw bit 2.
- R8: A pulse on either `fifo_unf_upper` or `fifo_unf_lower` sets raw bit 3.
- R9: When a source event and a clear of the same bit fall in one cycle, the raw bit stays set. For bit 0 the hold also stays and no restart pulse is sent.
- R10: After reset every register is 0, all sources are masked, the raw bits are clear, and `irq_any`, `mst_err_hold` and `mst_restart` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| mst_err_resp | input | 1 | Error response seen by the bus master |
| mst_err_hold | output | 1 | Holds the master in its error state |
| mst_restart | output | 1 | One-cycle release to start of frame |
| ph_vsync | input | 1 | Vertical sync phase active |
| ph_back | input | 1 | Back porch phase active |
| ph_active | input | 1 | Active video phase active |
| ph_front | input | 1 | Front porch phase active |
| base_ld_upper | input | 1 | Upper base copied into its current counter |
| base_ld_lower | input | 1 | Lower base copied into its current counter |
| fifo_unf_upper | input | 1 | Read from the empty upper FIFO |
| fifo_unf_lower | input | 1 | Read from the empty lower FIFO |
| irq_src | output | 4 | Masked per-source interrupts |
| irq_any | output | 1 | Combined interrupt |

## Verification
A source event and a software clear of the same bit can land in one cycle. The bench provokes this by driving the event pulse and the clear write on the same falling edge, for the next-base source and for the bus-error source. It then judges the outcome one cycle later. The raw bit must still read 1, and for the bus error the hold must still be high and no restart pulse may have appeared.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
    localparam int NSRC = 4;
    localparam int SEL_W = 2;

    localparam int SRC_BERR = 0;
    localparam int SRC_VCMP = 1;
    localparam int SRC_BASE = 2;
    localparam int SRC_UNF  = 3;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef enum logic [1:0] {
        REG_MASK = 2'd0,
        REG_RAW  = 2'd1,
        REG_CLR  = 2'd2,
        REG_CTRL = 2'd3
    } reg_sel_e;

    typedef enum logic [SEL_W-1:0] {
        PH_VSYNC  = 2'd0,
        PH_BACK   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_FRONT  = 2'd3
    } vphase_e;

    function automatic logic hit(input logic we, input logic [1:0] addr, input reg_sel_e sel);
        return we && (reg_sel_e'(addr) == sel);
    endfunction
endpackage

// File: rtl/disp_irq_vcmp.sv
module disp_irq_vcmp
    import disp_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  vphase_e          sel,
    input  logic [NSRC-1:0]  phase,
    output logic             entry
);
    logic [NSRC-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase;
    end

    // entry means the selected phase has just gone from inactive to active
    always_comb entry = phase[sel] & ~phase_q[sel];
endmodule

// File: rtl/disp_irq_status.sv
module disp_irq_status
    import disp_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t evt,
    input  src_vec_t clr,
    output src_vec_t raw
);
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)         bit_q <= 1'b0;
            else if (evt[i]) bit_q <= 1'b1;
            else if (clr[i]) bit_q <= 1'b0;
        end
        assign raw[i] = bit_q;
    end
endmodule

// File: rtl/disp_irq_errhold.sv
module disp_irq_errhold (
    input  logic clk,
    input  logic rst,
    input  logic err,
    input  logic clr,
    output logic hold,
    output logic restart
);
    typedef enum logic {ST_RUN, ST_HOLD} st_e;
    st_e  st_q;
    logic restart_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_RUN;
            restart_q <= 1'b0;
        end else begin
            restart_q <= 1'b0;
            if (err) begin
                st_q <= ST_HOLD;
            end else if (st_q == ST_HOLD && clr) begin
                st_q      <= ST_RUN;
                restart_q <= 1'b1;
            end
        end
    end

    assign hold    = (st_q == ST_HOLD);
    assign restart = restart_q;
endmodule

// File: rtl/disp_irq_unit.sv
module disp_irq_unit
    import disp_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              mst_err_resp,
    output logic              mst_err_hold,
    output logic              mst_restart,
    input  logic              ph_vsync,
    input  logic              ph_back,
    input  logic              ph_active,
    input  logic              ph_front,
    input  logic              base_ld_upper,
    input  logic              base_ld_lower,
    input  logic              fifo_unf_upper,
    input  logic              fifo_unf_lower,
    output logic [3:0]        irq_src,
    output logic              irq_any
);
    localparam int PAD_SRC = DATA_W - NSRC;
    localparam int PAD_SEL = DATA_W - SEL_W;

    src_vec_t raw_q;
    src_vec_t mask_q;
    vphase_e  sel_q;
    src_vec_t evt;
    src_vec_t clr;
    logic     vcmp_entry;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            sel_q  <= PH_VSYNC;
        end else begin
            if (hit(reg_we, reg_addr, REG_MASK)) mask_q <= reg_wdata[NSRC-1:0];
            if (hit(reg_we, reg_addr, REG_CTRL)) sel_q  <= vphase_e'(reg_wdata[SEL_W-1:0]);
        end
    end

    always_comb begin
        clr = hit(reg_we, reg_addr, REG_CLR) ? reg_wdata[NSRC-1:0] : '0;
        evt = '0;
        evt[SRC_BERR] = mst_err_resp;
        evt[SRC_VCMP] = vcmp_entry;
        evt[SRC_BASE] = base_ld_upper | base_ld_lower;
        evt[SRC_UNF]  = fifo_unf_upper | fifo_unf_lower;
    end

    disp_irq_vcmp u_vcmp (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel_q),
        .phase ({ph_front, ph_active, ph_back, ph_vsync}),
        .entry (vcmp_entry)
    );

    disp_irq_status u_status (
        .clk (clk),
        .rst (rst),
        .evt (evt),
        .clr (clr),
        .raw (raw_q)
    );

    disp_irq_errhold u_errhold (
        .clk     (clk),
        .rst     (rst),
        .err     (mst_err_resp),
        .clr     (clr[SRC_BERR]),
        .hold    (mst_err_hold),
        .restart (mst_restart)
    );

    assign irq_src = raw_q & mask_q;
    assign irq_any = |irq_src;

    always_comb begin
        case (reg_sel_e'(reg_addr))
            REG_MASK: reg_rdata = {{PAD_SRC{1'b0}}, mask_q};
            REG_RAW:  reg_rdata = {{PAD_SRC{1'b0}}, raw_q};
            REG_CTRL: reg_rdata = {{PAD_SEL{1'b0}}, sel_q};
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/disp_irq_unit_chk.sv
module disp_irq_unit_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [1:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              mst_err_resp,
    input logic              mst_err_hold,
    input logic              mst_restart,
    input logic              base_ld_upper,
    input logic              base_ld_lower,
    input logic              fifo_unf_upper,
    input logic              fifo_unf_lower,
    input logic [3:0]        irq_src,
    input logic              irq_any,
    input logic [3:0]        raw_q,
    input logic [3:0]        mask_q
);
    logic clr_wr;
    assign clr_wr = reg_we && (reg_addr == 2'd2);

    a_r2_src_masked: assert property (@(posedge clk) disable iff (rst)
        (irq_src & ~mask_q) == 4'd0 && irq_any == (|(raw_q & mask_q)));

    a_r4_err_sets: assert property (@(posedge clk) disable iff (rst)
        mst_err_resp |=> raw_q[0] && mst_err_hold);

    a_r4_hold_sticky: assert property (@(posedge clk) disable iff (rst)
        mst_err_hold && !(clr_wr && reg_wdata[0]) |=> mst_err_hold);

    a_r5_release: assert property (@(posedge clk) disable iff (rst)
        mst_err_hold && clr_wr && reg_wdata[0] && !mst_err_resp |=> !mst_err_hold && mst_restart);

    a_r5_one_pulse: assert property (@(posedge clk) disable iff (rst)
        mst_restart |=> !mst_restart);

    a_r7_base_sets: assert property (@(posedge clk) disable iff (rst)
        (base_ld_upper || base_ld_lower) |=> raw_q[2]);

    a_r8_unf_sets: assert property (@(posedge clk) disable iff (rst)
        (fifo_unf_upper || fifo_unf_lower) |=> raw_q[3]);

    a_r3_clear_unf: assert property (@(posedge clk) disable iff (rst)
        clr_wr && reg_wdata[3] && !fifo_unf_upper && !fifo_unf_lower |=> !raw_q[3]);

    a_r3_zero_keeps: assert property (@(posedge clk) disable iff (rst)
        raw_q[2] && !(clr_wr && reg_wdata[2]) |=> raw_q[2]);
endmodule

bind disp_irq_unit disp_irq_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .reg_we         (reg_we),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .mst_err_resp   (mst_err_resp),
    .mst_err_hold   (mst_err_hold),
    .mst_restart    (mst_restart),
    .base_ld_upper  (base_ld_upper),
    .base_ld_lower  (base_ld_lower),
    .fifo_unf_upper (fifo_unf_upper),
    .fifo_unf_lower (fifo_unf_lower),
    .irq_src        (irq_src),
    .irq_any        (irq_any),
    .raw_q          (raw_q),
    .mask_q         (mask_q)
);

// File: tb/disp_irq_unit_tb.sv
`timescale 1ns/1ps
module disp_irq_unit_tb;
    localparam int DATA_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic mst_err_resp = 1'b0;
    logic mst_err_hold, mst_restart;
    logic [3:0] ph = 4'b0;
    logic bl_u = 1'b0, bl_l = 1'b0, fu_u = 1'b0, fu_l = 1'b0;
    logic [3:0] irq_src;
    logic irq_any;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    disp_irq_unit #(.DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mst_err_resp(mst_err_resp), .mst_err_hold(mst_err_hold), .mst_restart(mst_restart),
        .ph_vsync(ph[0]), .ph_back(ph[1]), .ph_active(ph[2]), .ph_front(ph[3]),
        .base_ld_upper(bl_u), .base_ld_lower(bl_l),
        .fifo_unf_upper(fu_u), .fifo_unf_lower(fu_l),
        .irq_src(irq_src), .irq_any(irq_any)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DATA_W-1:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic raw_is(input string tag, input logic [3:0] exp);
        logic [DATA_W-1:0] d;
        rd(2'd1, d);
        chk(tag, d, {4'b0, exp});
    endtask

    task automatic t_reset;
        logic [DATA_W-1:0] d;
        rd(2'd0, d); chk("R10 mask after reset", d, 0);
        raw_is("R10 raw after reset", 4'h0);
        rd(2'd3, d); chk("R10 ctrl after reset", d, 0);
        chk("R10 outputs after reset", {irq_any, irq_src, mst_err_hold, mst_restart}, 0);
    endtask

    task automatic t_mask_and_raw;
        logic [DATA_W-1:0] d;
        @(negedge clk); fu_u = 1'b1;
        @(negedge clk); fu_u = 1'b0;
        raw_is("R8 R1 upper underflow seen while masked", 4'h8);
        chk("R2 masked source quiet", {irq_any, irq_src}, 0);
        wr(2'd0, 8'h08);
        rd(2'd0, d); chk("R2 mask readback", d, 8'h08);
        chk("R2 unmasked source drives outputs", {irq_any, irq_src}, {1'b1, 4'h8});
        wr(2'd2, 8'h00);
        raw_is("R3 zero clear has no effect", 4'h8);
        rd(2'd2, d); chk("R3 clear reads zero", d, 0);
        wr(2'd2, 8'h08);
        raw_is("R3 clear bit 3", 4'h0);
        chk("R2 combined falls after clear", irq_any, 0);
        @(negedge clk); fu_l = 1'b1;
        @(negedge clk); fu_l = 1'b0;
        raw_is("R8 lower underflow", 4'h8);
        wr(2'd2, 8'h08);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_base;
        @(negedge clk); bl_u = 1'b1;
        @(negedge clk); bl_u = 1'b0;
        raw_is("R7 upper base load", 4'h4);
        wr(2'd2, 8'h04);
        @(negedge clk); bl_l = 1'b1;
        @(negedge clk); bl_l = 1'b0;
        raw_is("R7 lower base load", 4'h4);
        wr(2'd0, 8'h03);
        chk("R2 other mask bits keep bit 2 off", {irq_any, irq_src}, 0);
        wr(2'd2, 8'h04);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_buserr;
        @(negedge clk); mst_err_resp = 1'b1;
        @(negedge clk); mst_err_resp = 1'b0;
        raw_is("R4 bus error raw", 4'h1);
        chk("R4 hold raised", mst_err_hold, 1);
        repeat (5) @(negedge clk);
        chk("R4 hold persists", mst_err_hold, 1);
        wr(2'd2, 8'h0E);
        chk("R4 other clears keep hold", {mst_err_hold, mst_restart}, 2'b10);
        wr(2'd2, 8'h01);
        chk("R5 hold dropped and restart", {mst_err_hold, mst_restart}, 2'b01);
        raw_is("R5 raw cleared", 4'h0);
        @(negedge clk);
        chk("R5 restart single cycle", mst_restart, 0);
    endtask

    task automatic t_vcmp;
        for (int s = 0; s < 4; s++) begin
            wr(2'd3, 8'(s));
            @(negedge clk); ph[(s + 1) % 4] = 1'b1;
            @(negedge clk);
            raw_is($sformatf("R6 unselected phase sel=%0d", s), 4'h0);
            ph[s] = 1'b1;
            @(negedge clk);
            raw_is($sformatf("R6 selected phase entry sel=%0d", s), 4'h2);
            wr(2'd2, 8'h02);
            @(negedge clk);
            raw_is($sformatf("R6 held phase no refire sel=%0d", s), 4'h0);
            ph = 4'b0;
            @(negedge clk);
        end
    endtask

    task automatic t_collide;
        @(negedge clk);
        bl_u = 1'b1; reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h04;
        @(negedge clk);
        bl_u = 1'b0; reg_we = 1'b0;
        raw_is("R9 base event beats clear", 4'h4);
        wr(2'd2, 8'h04);
        @(negedge clk); mst_err_resp = 1'b1;
        @(negedge clk); mst_err_resp = 1'b0;
        @(negedge clk);
        mst_err_resp = 1'b1; reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h01;
        @(negedge clk);
        mst_err_resp = 1'b0; reg_we = 1'b0;
        raw_is("R9 error event beats clear", 4'h1);
        chk("R9 hold kept, no restart", {mst_err_hold, mst_restart}, 2'b10);
        wr(2'd2, 8'h01);
        chk("R9 later clear releases", {mst_err_hold, mst_restart}, 2'b01);
    endtask

    initial begin
        #100000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mask_and_raw();
        t_base();
        t_buserr();
        t_vcmp();
        t_collide();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule